// File: doc/BRIEF.md
# Processor exception entry controller

This block takes a processor core from normal execution into an exception handler. The core presents at most one already-prioritised exception per cycle. Each request carries a kind code, the faulting PC, a flag that marks an instruction sitting in a branch delay slot, and a qualifier that marks a TLB miss as a refill. The block updates the control state it owns: the Status bits EXL, ERL, BEV, SR and NMI, the Cause BD bit and exception code, the three return-address registers (general, error and debug), the Debug DDBL bit, the watch register, and the debug-mode and user-mode flags.

One cycle after an accepted request, the block raises a single-cycle redirect pulse. With that pulse it presents the handler's fetch address. The address is chosen from the exception class, Status.BEV and, for refills, Status.EXL.

Logic outside the block handles the return from an exception. It restores Status, the user-mode flag and the watch register through a load interface.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous reset sets Status to 0x00400004 (BEV at bit 22 and ERL at bit 2). It sets Cause, the three return registers, Debug and the watch register to 0, clears the debug-mode and user-mode flags, and holds redirect low.
- R2: A request with a valid kind raises `redirect_o` for exactly one cycle, in the cycle after the request, with `fetch_pc_o` holding the vector. All register updates appear in that same cycle. Kind codes: 0 interrupt, 1 TLB modified, 2 TLB load miss, 3 TLB store miss, 4 load address error, 5 store address error, 6 syscall, 7 break, 8 reserved instruction, 9 overflow, 10 debug, 11 double debug, 12 soft reset, 13 NMI.
- R3: A debug or double-debug request has these effects:
  - The debug return register is loaded with PC-4 when the instruction is in a delay slot, and with PC otherwise.
  - The debug-mode flag is set and the user-mode flag is cleared.
  - Status and Cause are left unchanged.
  - The fetch address is 0xBFC00480.
- R4: A double-debug request also sets the DDBL bit (bit 3) of Debug.
- R5: Soft reset and NMI requests take the error path:
  - The error return register is loaded with PC-4 for a delay-slot instruction, and with PC otherwise.
  - Status ERL and BEV are set, other Status bits are kept, and the user-mode flag is cleared.
  - Cause, including BD, is unchanged.
  - The fetch address is 0xBFC00000.
- R6: Soft reset also sets Status bit 20 and clears the watch register. NMI also sets Status bit 19 and leaves the watch register alone.
- R7: A general exception (kinds 0 to 9) taken while Status.EXL (bit 1) is clear sets the general return register and Cause.BD (bit 31):
  - in a delay slot, the register gets PC-4 and BD is set;
  - otherwise, the register gets PC and BD is cleared.
- R8: A general exception taken while Status.EXL is set leaves the general return register and Cause.BD unchanged.
- R9: The general vector has a base of 0xBFC00200 when BEV is set and 0x80000000 when BEV is clear, plus an offset of 0x180. After entry, Status.EXL is set and the user-mode flag is clear.
- R10: A TLB load or store miss has an offset of 0x000 when the refill qualifier is 1 and EXL was clear. Any other kind with the qualifier set keeps the 0x180 offset.
- R11: A general exception writes its exception code into Cause bits 6:2 and keeps all other Cause bits. The codes, by kind, are:
  - interrupt 0, TLB modified 1, TLB load 2, TLB store 3;
  - load address error 4, store address error 5;
  - syscall 8, break 9, reserved instruction 10, overflow 12.
- R12: A load pulse with no request writes Status, the user-mode flag and the watch register in the next cycle. A load that coincides with a request is ignored.
- R13: Kind codes 14 and 15 are ignored: no redirect, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Exception request strobe |
| req_kind | input | 4 | Exception kind code |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_slot | input | 1 | Faulting instruction is in a delay slot |
| req_refill | input | 1 | TLB miss is a refill |
| ctx_load | input | 1 | Restore strobe from return logic |
| ctx_status | input | 32 | Status value to restore |
| ctx_user | input | 1 | User-mode flag to restore |
| ctx_watch | input | 32 | Watch register value to restore |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| fetch_pc_o | output | 32 | Handler fetch address |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | General return address |
| errorepc_o | output | 32 | Error-path return address |
| depc_o | output | 32 | Debug return address |
| debug_o | output | 32 | Debug register |
| watch_o | output | 32 | Watch register |
| debug_mode_o | output | 1 | Debug-mode flag |
| user_mode_o | output | 1 | User-mode flag |

## Verification
The properties assume that the request inputs are driven with settled values, and that reset is held low while those values are checked. The properties are written against the Status bit that was present in the request cycle, so they hold only when that bit is not changed in the same cycle by a competing load. The stimulus drives each request for exactly one cycle, starting at a falling clock edge. Before a request, it brings Status into the intended EXL and BEV state with a separate load pulse. The only load that coincides with a request is the one in the test for requirement R12.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN     = 32;
    localparam int CODE_W   = 5;
    localparam int KIND_W   = 4;

    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_NMI   = 19;
    localparam int ST_SR    = 20;
    localparam int ST_BEV   = 22;
    localparam int CA_BD    = 31;
    localparam int CA_LO    = 2;
    localparam int DB_DDBL  = 3;

    typedef enum logic [KIND_W-1:0] {
        EK_INT    = 4'd0,
        EK_TLBMOD = 4'd1,
        EK_TLBL   = 4'd2,
        EK_TLBS   = 4'd3,
        EK_ADEL   = 4'd4,
        EK_ADES   = 4'd5,
        EK_SYS    = 4'd6,
        EK_BRK    = 4'd7,
        EK_RI     = 4'd8,
        EK_OV     = 4'd9,
        EK_DBG    = 4'd10,
        EK_DDBL   = 4'd11,
        EK_SRST   = 4'd12,
        EK_NMI    = 4'd13
    } exc_kind_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_GEN  = 2'd1,
        CL_ERR  = 2'd2,
        CL_DBG  = 2'd3
    } exc_class_e;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] errepc;
        logic [XLEN-1:0] depc;
        logic [XLEN-1:0] debug;
        logic [XLEN-1:0] watch;
        logic            dmode;
        logic            umode;
        logic            redirect;
        logic [XLEN-1:0] fetch;
    } ctl_state_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
    import exc_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output exc_class_e        cls_o,
    output logic [CODE_W-1:0] code_o,
    output logic              tlb_miss_o
);
    always_comb begin
        cls_o      = CL_GEN;
        code_o     = '0;
        tlb_miss_o = 1'b0;
        case (kind_i)
            EK_INT:    code_o = 5'd0;
            EK_TLBMOD: code_o = 5'd1;
            EK_TLBL:   begin code_o = 5'd2; tlb_miss_o = 1'b1; end
            EK_TLBS:   begin code_o = 5'd3; tlb_miss_o = 1'b1; end
            EK_ADEL:   code_o = 5'd4;
            EK_ADES:   code_o = 5'd5;
            EK_SYS:    code_o = 5'd8;
            EK_BRK:    code_o = 5'd9;
            EK_RI:     code_o = 5'd10;
            EK_OV:     code_o = 5'd12;
            EK_DBG,
            EK_DDBL:   cls_o = CL_DBG;
            EK_SRST,
            EK_NMI:    cls_o = CL_ERR;
            default:   cls_o = CL_NONE;
        endcase
    end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int W     = 32,
    parameter int ISTEP = 4
) (
    input  logic [W-1:0] pc_i,
    input  logic         in_slot_i,
    output logic [W-1:0] ret_o
);
    localparam logic [W-1:0] STEP = W'(ISTEP);

    // A delay-slot instruction resumes at its branch, one instruction earlier.
    assign ret_o = in_slot_i ? (pc_i - STEP) : pc_i;
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] GEN_BASE_BOOT = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] GEN_BASE_RUN  = 32'h8000_0000,
    parameter logic [XLEN-1:0] GEN_OFFSET    = 32'h0000_0180,
    parameter logic [XLEN-1:0] REFILL_OFFSET = 32'h0000_0000,
    parameter logic [XLEN-1:0] ERR_VEC       = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] DBG_VEC       = 32'hBFC0_0480
) (
    input  exc_class_e      cls_i,
    input  logic            bev_i,
    input  logic            exl_i,
    input  logic            refill_i,
    input  logic            tlb_miss_i,
    output logic [XLEN-1:0] vec_o
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    always_comb begin
        base  = bev_i ? GEN_BASE_BOOT : GEN_BASE_RUN;
        offs  = (tlb_miss_i && refill_i && !exl_i) ? REFILL_OFFSET : GEN_OFFSET;
        case (cls_i)
            CL_GEN:  vec_o = base + offs;
            CL_ERR:  vec_o = ERR_VEC;
            CL_DBG:  vec_o = DBG_VEC;
            default: vec_o = '0;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ISTEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [XLEN-1:0]   req_pc,
    input  logic              req_in_slot,
    input  logic              req_refill,
    input  logic              ctx_load,
    input  logic [XLEN-1:0]   ctx_status,
    input  logic              ctx_user,
    input  logic [XLEN-1:0]   ctx_watch,
    output logic              redirect_o,
    output logic [XLEN-1:0]   fetch_pc_o,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   errorepc_o,
    output logic [XLEN-1:0]   depc_o,
    output logic [XLEN-1:0]   debug_o,
    output logic [XLEN-1:0]   watch_o,
    output logic              debug_mode_o,
    output logic              user_mode_o
);
    localparam logic [XLEN-1:0] STATUS_RST = (XLEN'(1) << ST_BEV) | (XLEN'(1) << ST_ERL);

    ctl_state_t        st_d, st_q;
    exc_class_e        cls;
    logic [CODE_W-1:0] code;
    logic              tlb_miss;
    logic [XLEN-1:0]   ret_addr;
    logic [XLEN-1:0]   vec;
    logic              take;

    exc_decode u_dec (
        .kind_i     (req_kind),
        .cls_o      (cls),
        .code_o     (code),
        .tlb_miss_o (tlb_miss)
    );

    exc_ret_addr #(.W(XLEN), .ISTEP(ISTEP)) u_ret (
        .pc_i      (req_pc),
        .in_slot_i (req_in_slot),
        .ret_o     (ret_addr)
    );

    exc_vector u_vec (
        .cls_i      (cls),
        .bev_i      (st_q.status[ST_BEV]),
        .exl_i      (st_q.status[ST_EXL]),
        .refill_i   (req_refill),
        .tlb_miss_i (tlb_miss),
        .vec_o      (vec)
    );

    assign take = req_valid && (cls != CL_NONE);

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        if (take) begin
            st_d.redirect = 1'b1;
            st_d.fetch    = vec;
            st_d.umode    = 1'b0;
            case (cls)
                CL_DBG: begin
                    st_d.depc  = ret_addr;
                    st_d.dmode = 1'b1;
                    if (req_kind == EK_DDBL)
                        st_d.debug[DB_DDBL] = 1'b1;
                end
                CL_ERR: begin
                    if (req_kind == EK_SRST) begin
                        st_d.status[ST_SR] = 1'b1;
                        st_d.watch         = '0;
                    end else begin
                        st_d.status[ST_NMI] = 1'b1;
                    end
                    st_d.errepc          = ret_addr;
                    st_d.status[ST_ERL]  = 1'b1;
                    st_d.status[ST_BEV]  = 1'b1;
                end
                default: begin
                    if (!st_q.status[ST_EXL]) begin
                        st_d.epc          = ret_addr;
                        st_d.cause[CA_BD] = req_in_slot;
                    end
                    st_d.status[ST_EXL]             = 1'b1;
                    st_d.cause[CA_LO+CODE_W-1:CA_LO] = code;
                end
            endcase
        end else if (ctx_load) begin
            st_d.status = ctx_status;
            st_d.umode  = ctx_user;
            st_d.watch  = ctx_watch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.status <= STATUS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o   = st_q.redirect;
    assign fetch_pc_o   = st_q.fetch;
    assign status_o     = st_q.status;
    assign cause_o      = st_q.cause;
    assign epc_o        = st_q.epc;
    assign errorepc_o   = st_q.errepc;
    assign depc_o       = st_q.depc;
    assign debug_o      = st_q.debug;
    assign watch_o      = st_q.watch;
    assign debug_mode_o = st_q.dmode;
    assign user_mode_o  = st_q.umode;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
    import exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic [XLEN-1:0]   status_o,
    input logic [XLEN-1:0]   cause_o,
    input logic [XLEN-1:0]   epc_o,
    input logic              redirect_o,
    input logic [XLEN-1:0]   fetch_pc_o,
    input logic              debug_mode_o,
    input logic              user_mode_o
);
    assert_no_spurious_redirect_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid) |-> !redirect_o);

    assert_debug_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && (req_kind == EK_DBG))
        |-> (debug_mode_o && !user_mode_o && fetch_pc_o == 32'hBFC0_0480));

    assert_error_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && (req_kind == EK_SRST || req_kind == EK_NMI))
        |-> (status_o[ST_ERL] && status_o[ST_BEV] && $stable(cause_o)));

    assert_frozen_epc_R8: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && status_o[ST_EXL] && req_kind <= EK_OV)
        |-> ($stable(epc_o) && $stable(cause_o[CA_BD])));

    assert_exl_after_general_R9: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_kind <= EK_OV) |-> (status_o[ST_EXL] && !user_mode_o));

    assert_bad_kind_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_kind > EK_NMI) |-> (!redirect_o && $stable(status_o)));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .status_o     (status_o),
    .cause_o      (cause_o),
    .epc_o        (epc_o),
    .redirect_o   (redirect_o),
    .fetch_pc_o   (fetch_pc_o),
    .debug_mode_o (debug_mode_o),
    .user_mode_o  (user_mode_o)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic [31:0] req_pc = '0;
    logic        req_in_slot = 1'b0;
    logic        req_refill = 1'b0;
    logic        ctx_load = 1'b0;
    logic [31:0] ctx_status = '0;
    logic        ctx_user = 1'b0;
    logic [31:0] ctx_watch = '0;
    logic        redirect_o;
    logic [31:0] fetch_pc_o, status_o, cause_o, epc_o, errorepc_o, depc_o, debug_o, watch_o;
    logic        debug_mode_o, user_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_entry_ctrl uut (.*);

    typedef struct packed {
        logic [3:0]  kind;
        logic [31:0] pc;
        logic        slot;
        logic        refill;
        logic [31:0] st_pre;
        logic [31:0] exp_pc;
        logic [31:0] exp_epc;
        logic [31:0] exp_cause;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{4'd0, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_0000, 32'h8000_0180, 32'h0000_1000, 32'h0000_0000},
        '{4'd2, 32'h0000_2004, 1'b1, 1'b1, 32'h0000_0000, 32'h8000_0000, 32'h0000_2000, 32'h8000_0008},
        '{4'd3, 32'h0000_3000, 1'b0, 1'b1, 32'h0040_0000, 32'hBFC0_0200, 32'h0000_3000, 32'h0000_000C},
        '{4'd2, 32'h0000_4000, 1'b0, 1'b1, 32'h0000_0002, 32'h8000_0180, 32'h0000_0000, 32'h0000_0008},
        '{4'd9, 32'h0000_5008, 1'b1, 1'b0, 32'h0040_0002, 32'hBFC0_0380, 32'h0000_0000, 32'h0000_0030},
        '{4'd6, 32'h0000_600C, 1'b1, 1'b0, 32'h0000_0000, 32'h8000_0180, 32'h0000_6008, 32'h8000_0020},
        '{4'd5, 32'h0000_7000, 1'b0, 1'b1, 32'h0000_0000, 32'h8000_0180, 32'h0000_7000, 32'h0000_0014},
        '{4'd8, 32'h0000_8004, 1'b1, 1'b0, 32'h0040_0000, 32'hBFC0_0380, 32'h0000_8000, 32'h8000_0028}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; ctx_load = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [31:0] st, input logic u, input logic [31:0] w);
        ctx_load = 1'b1; ctx_status = st; ctx_user = u; ctx_watch = w;
        @(negedge clk);
        ctx_load = 1'b0;
    endtask

    // Drives one request for a single cycle; returns when its results are visible.
    task automatic fire(input logic [3:0] k, input logic [31:0] pc, input logic s, input logic r);
        req_valid = 1'b1; req_kind = k; req_pc = pc; req_in_slot = s; req_refill = r;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 status", status_o, 32'h0040_0004);
        check("R1 cause", cause_o, 32'h0);
        check("R1 epc", epc_o, 32'h0);
        check("R1 errorepc", errorepc_o, 32'h0);
        check("R1 depc", depc_o, 32'h0);
        check("R1 debug", debug_o, 32'h0);
        check("R1 watch", watch_o, 32'h0);
        check("R1 flags", {30'd0, debug_mode_o, user_mode_o}, 32'h0);
        check("R1 redirect", {31'd0, redirect_o}, 32'h0);

        // General exception table: R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            do_reset();
            load(VT[i].st_pre, 1'b1, 32'h0);
            fire(VT[i].kind, VT[i].pc, VT[i].slot, VT[i].refill);
            check($sformatf("R2 redirect v%0d", i), {31'd0, redirect_o}, 32'h1);
            check($sformatf("R9 R10 fetch v%0d", i), fetch_pc_o, VT[i].exp_pc);
            check($sformatf("R7 R8 epc v%0d", i), epc_o, VT[i].exp_epc);
            check($sformatf("R11 cause v%0d", i), cause_o, VT[i].exp_cause);
            check($sformatf("R9 status v%0d", i), status_o, VT[i].st_pre | 32'h2);
            check($sformatf("R9 user v%0d", i), {31'd0, user_mode_o}, 32'h0);
            @(negedge clk);
            check($sformatf("R2 pulse width v%0d", i), {31'd0, redirect_o}, 32'h0);
        end

        // R8 R11: BD held and code replaced while EXL set
        do_reset();
        load(32'h0, 1'b0, 32'h0);
        fire(4'd6, 32'h0000_0010, 1'b1, 1'b0);
        fire(4'd7, 32'h0000_0040, 1'b0, 1'b0);
        check("R11 code replaced BD kept", cause_o, 32'h8000_0024);
        check("R8 epc held", epc_o, 32'h0000_000C);

        // R5 R6 soft reset keeps Cause and clears watch
        load(32'h0000_0011, 1'b1, 32'h0000_ABCD);
        fire(4'd12, 32'h0000_0300, 1'b0, 1'b0);
        check("R5 errorepc", errorepc_o, 32'h0000_0300);
        check("R6 soft reset status", status_o, 32'h0050_0015);
        check("R6 watch cleared", watch_o, 32'h0);
        check("R5 cause kept", cause_o, 32'h8000_0024);
        check("R5 fetch", fetch_pc_o, 32'hBFC0_0000);
        check("R5 user cleared", {31'd0, user_mode_o}, 32'h0);

        // R5 R6 NMI from delay slot
        do_reset();
        load(32'h0000_0011, 1'b1, 32'h0000_0055);
        fire(4'd13, 32'h0000_0204, 1'b1, 1'b0);
        check("R5 errorepc slot", errorepc_o, 32'h0000_0200);
        check("R6 nmi status", status_o, 32'h0048_0015);
        check("R6 nmi watch kept", watch_o, 32'h0000_0055);
        check("R2 redirect nmi", {31'd0, redirect_o}, 32'h1);

        // R3 R4 debug entries
        do_reset();
        load(32'h0040_0004, 1'b1, 32'h0);
        fire(4'd10, 32'h0000_0100, 1'b1, 1'b0);
        check("R3 depc slot", depc_o, 32'h0000_00FC);
        check("R3 flags", {30'd0, debug_mode_o, user_mode_o}, 32'h2);
        check("R3 fetch", fetch_pc_o, 32'hBFC0_0480);
        check("R3 status kept", status_o, 32'h0040_0004);
        check("R3 cause kept", cause_o, 32'h0);
        check("R4 no ddbl on plain debug", debug_o, 32'h0);
        fire(4'd11, 32'h0000_0120, 1'b0, 1'b0);
        check("R3 depc no slot", depc_o, 32'h0000_0120);
        check("R4 ddbl bit", debug_o, 32'h0000_0008);

        // R12 load alone, then load coinciding with request
        do_reset();
        load(32'h1234_0000, 1'b1, 32'h0000_0077);
        check("R12 load status", status_o, 32'h1234_0000);
        check("R12 load user", {31'd0, user_mode_o}, 32'h1);
        check("R12 load watch", watch_o, 32'h0000_0077);
        do_reset();
        ctx_load = 1'b1; ctx_status = 32'h0; ctx_user = 1'b1; ctx_watch = 32'h99;
        fire(4'd6, 32'h0000_0500, 1'b0, 1'b0);
        ctx_load = 1'b0;
        check("R12 load ignored status", status_o, 32'h0040_0006);
        check("R12 load ignored watch", watch_o, 32'h0);
        check("R12 fetch", fetch_pc_o, 32'hBFC0_0380);

        // R13 undefined kinds ignored
        do_reset();
        fire(4'd14, 32'h0000_0600, 1'b1, 1'b0);
        check("R13 no redirect", {31'd0, redirect_o}, 32'h0);
        check("R13 status", status_o, 32'h0040_0004);
        fire(4'd15, 32'h0000_0700, 1'b0, 1'b0);
        check("R13 epc", epc_o, 32'h0);
        check("R13 cause", cause_o, 32'h0);
        check("R13 errorepc depc", errorepc_o | depc_o, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule